// File: doc/BRIEF.md
# Handshaked Byte Link Port

This block is the peripheral end of a byte-wide link to a host processor. Three active-low handshake lines govern the exchange. The host drives a transfer-active line and an acknowledge line. The block drives a data-request line back to the host. A direction input picks the way bytes travel. When the host sends, each handshake step copies the shift register into a small capture buffer. When the block answers, each step loads the next byte of a reply buffer into the shift register.

The local controller reads and writes the shift register directly. It clears the shift flag after it has served it. It loads reply bytes through a write port, then starts a reply by giving its length. When the host ends a transfer, the block emits a one-cycle packet strobe and the number of captured bytes. The captured bytes can then be read out by index. Serial bit timing is not modelled: each byte moves as one parallel word.

Top module: `hslink_port`

## Requirements
- R1: After reset, `data_req_n` is 1, `shift_flag` is 0 and `pkt_valid` is 0.
- R2: While `xfer_n` is 0 and `host_tx` is 1, a change of the pair {`ack_n`, `xfer_n`} from its value in the previous cycle appends `sh_q` to the capture buffer and sets `shift_flag` at the next edge. A cycle with no change captures nothing.
- R3: The capture buffer holds at most 16 bytes. A step that finds it full stores nothing and does not set `shift_flag`, and the reported length stays 16.
- R4: While `xfer_n` is 0 and `host_tx` is 0, a pair change with reply bytes remaining loads the next reply byte into `sh_q` and sets `shift_flag`. With no bytes remaining, a step changes nothing.
- R5: Loading the last reply byte drives `data_req_n` to 1.
- R6: While `xfer_n` is 1 and reply bytes remain, `data_req_n` is driven to 0, except in a cycle that R7 covers.
- R7: While `xfer_n` is 1 and was 1 in the previous cycle, a change of `ack_n` copies the new `ack_n` level into `data_req_n` and sets `shift_flag`.
- R8: In the first cycle where `xfer_n` is 1 after being 0, the transfer ends. `shift_flag` is set. If at least one byte was captured, `pkt_valid` pulses for one cycle and `pkt_len` gives the count. The capture count then restarts at 0. An empty transfer gives no strobe.
- R9: `rep_load` sets the reply length to `rep_len`, restarts reading at reply byte 0 and sets `shift_flag`.
- R10: `flag_clr` clears `shift_flag`, but a flag-setting event in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_n | input | 1 | Host transfer active, active low |
| ack_n | input | 1 | Host acknowledge, active low |
| host_tx | input | 1 | 1: host sends bytes; 0: block sends reply bytes |
| sh_wr | input | 1 | Write `sh_din` into the shift register |
| sh_din | input | 8 | Shift register write data |
| sh_q | output | 8 | Shift register contents |
| flag_clr | input | 1 | Clear the shift flag |
| shift_flag | output | 1 | Shift event flag |
| data_req_n | output | 1 | Data request to host, active low |
| rep_wr | input | 1 | Reply buffer write strobe |
| rep_waddr | input | 7 | Reply buffer write index |
| rep_wdata | input | 8 | Reply buffer write data |
| rep_load | input | 1 | Start a reply of `rep_len` bytes |
| rep_len | input | 8 | Reply length in bytes |
| pkt_valid | output | 1 | One-cycle strobe: host packet complete |
| pkt_len | output | 5 | Byte count of the last reported packet |
| pkt_raddr | input | 4 | Capture buffer read index |
| pkt_rdata | output | 8 | Capture buffer byte at `pkt_raddr` |

## Verification
The bench holds a handshake level steady for one cycle to show that an unchanged pair moves no byte. A design that looked at levels instead of changes would capture bytes twice. The bench sends eighteen steps into the sixteen-byte buffer. A design with an off-by-one limit would report 17 bytes or would still raise the flag on a dropped step. The bench drains a three-byte reply and then steps once more. A wrong end test would either miss raising `data_req_n` on the third byte or read past the end of the buffer. The bench also checks an empty transfer, a held idle level after a strobe, and a clear that collides with a set. These expose a design that strobes with no data, repeats the strobe, or lets the clear win.

// File: rtl/hslink_port.sv
module hslink_port #(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  parameter int DW        = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             xfer_n,
  input  logic                             ack_n,
  input  logic                             host_tx,
  input  logic                             sh_wr,
  input  logic [DW-1:0]                    sh_din,
  output logic [DW-1:0]                    sh_q,
  input  logic                             flag_clr,
  output logic                             shift_flag,
  output logic                             data_req_n,
  input  logic                             rep_wr,
  input  logic [$clog2(IN_DEPTH)-1:0]      rep_waddr,
  input  logic [DW-1:0]                    rep_wdata,
  input  logic                             rep_load,
  input  logic [$clog2(IN_DEPTH+1)-1:0]    rep_len,
  output logic                             pkt_valid,
  output logic [$clog2(OUT_DEPTH+1)-1:0]   pkt_len,
  input  logic [$clog2(OUT_DEPTH)-1:0]     pkt_raddr,
  output logic [DW-1:0]                    pkt_rdata
);
  localparam int OCW = $clog2(OUT_DEPTH+1);
  localparam int ICW = $clog2(IN_DEPTH+1);
  localparam int OAW = $clog2(OUT_DEPTH);
  localparam int IAW = $clog2(IN_DEPTH);
  localparam logic [OCW-1:0] OMAX = OCW'(OUT_DEPTH);

  logic [DW-1:0]  out_mem [OUT_DEPTH];
  logic [DW-1:0]  in_mem  [IN_DEPTH];
  logic [OCW-1:0] out_cnt;
  logic [ICW-1:0] rd_idx, rep_size;
  logic           prev_ack, prev_xfer;

  wire active   = !xfer_n;
  wire pair_chg = {ack_n, xfer_n} != {prev_ack, prev_xfer};
  wire pend     = rd_idx < rep_size;
  wire cap      = active && host_tx && pair_chg && (out_cnt < OMAX);
  wire feed     = active && !host_tx && pair_chg && pend;
  wire sync     = !active && prev_xfer && (ack_n != prev_ack);
  wire done     = !active && !sync && !prev_xfer;
  wire set_flag = cap || feed || sync || done || rep_load;

  assign pkt_rdata = out_mem[pkt_raddr];

  always_ff @(posedge clk) begin
    if (cap) out_mem[out_cnt[OAW-1:0]] <= sh_q;
    if (rep_wr) in_mem[rep_waddr] <= rep_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      shift_flag <= 1'b0;
      data_req_n <= 1'b1;
      pkt_valid  <= 1'b0;
      pkt_len    <= '0;
      out_cnt    <= '0;
      rd_idx     <= '0;
      rep_size   <= '0;
      prev_ack   <= 1'b1;
      prev_xfer  <= 1'b1;
    end else begin
      prev_ack  <= ack_n;
      prev_xfer <= xfer_n;
      pkt_valid <= 1'b0;
      if (flag_clr) shift_flag <= 1'b0;
      if (set_flag) shift_flag <= 1'b1;
      if (sh_wr) sh_q <= sh_din;
      if (cap) out_cnt <= out_cnt + OCW'(1);
      if (feed) begin
        sh_q   <= in_mem[rd_idx[IAW-1:0]];
        rd_idx <= rd_idx + ICW'(1);
        if (rd_idx + ICW'(1) >= rep_size) data_req_n <= 1'b1;
      end
      if (sync) data_req_n <= ack_n;
      if (!active && !sync && pend) data_req_n <= 1'b0;
      if (done) begin
        out_cnt <= '0;
        if (out_cnt != '0) begin
          pkt_valid <= 1'b1;
          pkt_len   <= out_cnt;
        end
      end
      if (rep_load) begin
        rep_size <= rep_len;
        rd_idx   <= '0;
      end
    end
  end
endmodule

// File: rtl/hslink_port_chk.sv
module hslink_port_chk #(
  parameter int OUT_DEPTH = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           xfer_n,
  input logic                           ack_n,
  input logic                           flag_clr,
  input logic                           shift_flag,
  input logic                           data_req_n,
  input logic                           pkt_valid,
  input logic [$clog2(OUT_DEPTH+1)-1:0] pkt_len
);
  localparam int OCW = $clog2(OUT_DEPTH+1);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);

  assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len != '0) && (pkt_len <= OCW'(OUT_DEPTH)));

  assert_strobe_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> $past(xfer_n) && !$past(xfer_n, 2));

  assert_flag_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_flag) |-> $past(flag_clr));

  assert_idle_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_n && $past(xfer_n) && (ack_n != $past(ack_n))) |=> (data_req_n == $past(ack_n)));

  assert_idle_sync_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_n && $past(xfer_n) && (ack_n != $past(ack_n))) |=> shift_flag);
endmodule

bind hslink_port hslink_port_chk #(.OUT_DEPTH(OUT_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_n(xfer_n), .ack_n(ack_n),
  .flag_clr(flag_clr), .shift_flag(shift_flag), .data_req_n(data_req_n),
  .pkt_valid(pkt_valid), .pkt_len(pkt_len)
);

// File: tb/hslink_port_tb.sv
module hslink_port_tb;
  logic       clk = 0, rst_n = 0;
  logic       xfer_n = 1, ack_n = 1, host_tx = 1, sh_wr = 0, flag_clr = 0;
  logic [7:0] sh_din = 0, sh_q, rep_wdata = 0, rep_len = 0, pkt_rdata;
  logic       shift_flag, data_req_n, rep_wr = 0, rep_load = 0, pkt_valid;
  logic [6:0] rep_waddr = 0;
  logic [4:0] pkt_len;
  logic [3:0] pkt_raddr = 0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  hslink_port u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_n(xfer_n), .ack_n(ack_n), .host_tx(host_tx),
    .sh_wr(sh_wr), .sh_din(sh_din), .sh_q(sh_q), .flag_clr(flag_clr),
    .shift_flag(shift_flag), .data_req_n(data_req_n), .rep_wr(rep_wr),
    .rep_waddr(rep_waddr), .rep_wdata(rep_wdata), .rep_load(rep_load),
    .rep_len(rep_len), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_raddr(pkt_raddr), .pkt_rdata(pkt_rdata)
  );

  // fields: [15]xfer_n [14]ack_n [13]sh_wr [12:5]sh_din [4]flag_clr [3]flag [2]req_n [1]pkt_valid
  localparam logic [15:0] VEC [10] = '{
    {1'b1, 1'b1, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 8'hB2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) tick;
    rst_n = 1;
    tick;
    chk("R1 req", data_req_n, 1); chk("R1 flag", shift_flag, 0); chk("R1 pkt", pkt_valid, 0);

    // R2, R8, R7, R10 vector walk with host sending
    for (int i = 0; i < 10; i++) begin
      {xfer_n, ack_n, sh_wr} = VEC[i][15:13];
      sh_din = VEC[i][12:5];
      flag_clr = VEC[i][4];
      tick;
      chk($sformatf("R2/R7/R8/R10 vec%0d flag", i), shift_flag, VEC[i][3]);
      chk($sformatf("R6/R7 vec%0d req", i), data_req_n, VEC[i][2]);
      chk($sformatf("R8 vec%0d strobe", i), pkt_valid, VEC[i][1]);
    end
    sh_wr = 0; flag_clr = 0;
    chk("R8 len", pkt_len, 2);
    pkt_raddr = 0; #1 chk("R2 byte0", pkt_rdata, 8'hA1);
    pkt_raddr = 1; #1 chk("R2 byte1", pkt_rdata, 8'hB2);

    // R8 empty transfer, reply direction, no reply pending
    host_tx = 0; xfer_n = 0; flag_clr = 1; tick;
    chk("R4 no reply flag", shift_flag, 0);
    flag_clr = 0; xfer_n = 1; tick;
    chk("R8 empty flag", shift_flag, 1); chk("R8 empty strobe", pkt_valid, 0);

    // R3 overflow
    host_tx = 1;
    for (int i = 0; i < 18; i++) begin
      sh_wr = 1; sh_din = 8'(i); flag_clr = 1; tick;
      sh_wr = 0; flag_clr = 0;
      if (i == 0) xfer_n = 0; else ack_n = ~ack_n;
      tick;
      chk($sformatf("R3 step%0d flag", i), shift_flag, (i < 16));
    end
    xfer_n = 1; tick;
    chk("R3 strobe", pkt_valid, 1); chk("R3 len", pkt_len, 16);
    pkt_raddr = 15; #1 chk("R3 last byte", pkt_rdata, 8'd15);
    pkt_raddr = 0;  #1 chk("R3 first byte", pkt_rdata, 8'd0);

    // R9 R6 R4 R5 reply path
    host_tx = 0;
    for (int i = 0; i < 3; i++) begin
      rep_wr = 1; rep_waddr = 7'(i); rep_wdata = 8'(8'h11 * (i + 1)); tick;
    end
    rep_wr = 0; flag_clr = 1; tick;
    flag_clr = 0; rep_load = 1; rep_len = 3; tick;
    chk("R9 load flag", shift_flag, 1);
    rep_load = 0; flag_clr = 1; tick;
    chk("R6 pending req", data_req_n, 0);
    flag_clr = 0;
    for (int i = 0; i < 4; i++) begin
      flag_clr = 1; tick; flag_clr = 0;
      if (i == 0) xfer_n = 0; else ack_n = ~ack_n;
      tick;
      chk($sformatf("R4 step%0d data", i), sh_q, (i < 3) ? 8'h11 * (i + 1) : 8'h33);
      chk($sformatf("R4 step%0d flag", i), shift_flag, (i < 3));
      chk($sformatf("R5 step%0d req", i), data_req_n, (i >= 2));
    end
    xfer_n = 1; tick;
    chk("R8 reply end strobe", pkt_valid, 0); chk("R8 reply end flag", shift_flag, 1);
    chk("R5 req stays", data_req_n, 1);

    // R9 reload restarts index
    rep_load = 1; rep_len = 1; tick; rep_load = 0;
    xfer_n = 0; tick;
    chk("R9 restart data", sh_q, 8'h11);
    chk("R5 single req", data_req_n, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule